// File: doc/BRIEF.md
# Egress Timestamp Queue with Register Window

This block keeps the transmit timestamps of outgoing precision-time event messages until software collects them. Every cycle in which the capture strobe is high, it stores one record: the domain number, the message type, the sequence ID, the low five bits of the seconds count and the 30-bit nanoseconds count of the local time counter. Records go into a small first-in first-out store, and software removes them one at a time through a 16-bit register port.

To collect a record, software writes the pop command. The oldest record is then copied into a four-word read window and taken out of the store. Software then reads the four words. The window keeps its contents until the next pop command. A pop while the store is empty clears the window, and its valid bit then reads 0.

A level interrupt, gated by an enable bit, stays high for as long as records are waiting. It needs no acknowledge. A capture that arrives while the store is full is dropped and sets a sticky overflow flag.

Top module: `egress_ts_fifo`

## Requirements
- R1: Window word 0 (offset 0) carries the domain number in bits 7:0, the message type in bits 11:8, seconds bits 4:2 in bits 14:12 and the valid flag in bit 15.
- R2: Window word 1 (offset 1) carries the 16-bit sequence ID.
- R3: Window word 2 (offset 2) carries nanoseconds bits 15:0. Window word 3 (offset 3) carries nanoseconds bits 29:16 in bits 13:0 and seconds bits 1:0 in bits 15:14.
- R4: Writing a 1 to bit 0 of the pop register (offset 4) loads the oldest stored record into the window with valid = 1 and removes that record. Records come out in capture order. A write with bit 0 = 0 changes nothing.
- R5: A pop while the store is empty sets all four window words to 0, including the valid flag.
- R6: Between pop commands the window does not change, even when new records are captured.
- R7: The irq output is registered. It is 1 exactly when, at the previous clock edge, the interrupt enable (offset 5, bit 0) was 1 and the store held at least one record. It needs no acknowledge. Status bit 0 (offset 6) reads 1 while the store is not empty.
- R8: The store holds DEPTH records (8 by default). A capture while the store is full is dropped and sets the sticky overflow flag (status bit 1). Writing 1 to status bit 1 clears the flag.
- R9: After a synchronous reset, the window words, the status register, the interrupt enable and irq all read 0.
- R10: rd_data is registered. It shows the register that addr selected at the previous clock edge. Offsets 4 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_valid | input | 1 | Capture strobe, one record per cycle |
| cap_domain | input | 8 | Domain number of the message |
| cap_msgtype | input | 4 | Message type |
| cap_seqid | input | 16 | Sequence ID |
| cap_sec | input | 5 | Low five bits of the seconds count |
| cap_nsec | input | 30 | Nanoseconds count |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset for both read and write |
| wdata | input | 16 | Register write data |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Level interrupt: records are waiting |

## Verification
The bound checker checks on every cycle that:
- the window holds still between pop commands;
- an empty pop clears the window, and a pop that finds data sets the valid bit;
- irq stays low while the enable is off or the store is empty;
- a capture into a full store leaves the count unchanged and sets the overflow flag;
- the overflow flag stays set until it is cleared.

Only the bench scenarios can show the things that need a reference model of the contents: the exact bit packing of each word, the first-in first-out order over a full store, which records survive an overflow, and the reset and read-back values.

// File: rtl/egts_pkg.sv
package egts_pkg;
  localparam int WORD_W = 16;
  localparam int REG_AW = 3;
  localparam int WIN_W  = 4 * WORD_W;

  localparam logic [REG_AW-1:0] OFS_W0   = 3'd0;
  localparam logic [REG_AW-1:0] OFS_W1   = 3'd1;
  localparam logic [REG_AW-1:0] OFS_W2   = 3'd2;
  localparam logic [REG_AW-1:0] OFS_W3   = 3'd3;
  localparam logic [REG_AW-1:0] OFS_POP  = 3'd4;
  localparam logic [REG_AW-1:0] OFS_IEN  = 3'd5;
  localparam logic [REG_AW-1:0] OFS_STAT = 3'd6;

  typedef struct packed {
    logic [7:0]  dom;
    logic [3:0]  mtype;
    logic [15:0] seq;
    logic [4:0]  sec;
    logic [29:0] ns;
  } ts_rec_t;

  // Window layout, word 3 in the top bits.
  function automatic logic [WIN_W-1:0] pack_window(ts_rec_t r, logic vld);
    logic [WORD_W-1:0] w0, w1, w2, w3;
    w0 = {vld, r.sec[4:2], r.mtype, r.dom};
    w1 = r.seq;
    w2 = r.ns[15:0];
    w3 = {r.sec[1:0], r.ns[29:16]};
    return {w3, w2, w1, w0};
  endfunction
endpackage

// File: rtl/egts_store.sv
module egts_store
  import egts_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  ts_rec_t       push_rec,
  input  logic          pop,
  output ts_rec_t       win_rec,
  output logic          win_vld,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          drop
);
  ts_rec_t       mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign drop    = push && full;

  function automatic logic [PW-1:0] next_ptr(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Storage array: write port only, no reset, so it can map to RAM.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_rec;
  end

  // Registered read port that feeds the window.
  always_ff @(posedge clk) begin
    if (rst) begin
      win_rec <= '0;
      win_vld <= 1'b0;
    end else if (pop) begin
      win_vld <= !empty;
      win_rec <= empty ? '0 : mem[rp];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= next_ptr(wp);
      if (pop_ok)  rp <= next_ptr(rp);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/egts_regs.sv
module egts_regs
  import egts_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WIN_W-1:0]  win_word,
  input  logic              fifo_empty,
  input  logic              drop,
  output logic              pop_cmd,
  output logic              irq_en,
  output logic              ovf,
  output logic              irq,
  output logic [WORD_W-1:0] rd_data
);
  logic              ovf_clr;
  logic [WORD_W-1:0] rd_mux;
  logic              unused_wbits;

  assign unused_wbits = ^wdata[WORD_W-1:2];
  assign pop_cmd = wr_en && (addr == OFS_POP) && wdata[0];
  assign ovf_clr = wr_en && (addr == OFS_STAT) && wdata[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en <= 1'b0;
      ovf    <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (wr_en && addr == OFS_IEN) irq_en <= wdata[0];
      if (drop)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
      irq <= irq_en && !fifo_empty;
    end
  end

  always_comb begin
    case (addr)
      OFS_W0:   rd_mux = win_word[0*WORD_W +: WORD_W];
      OFS_W1:   rd_mux = win_word[1*WORD_W +: WORD_W];
      OFS_W2:   rd_mux = win_word[2*WORD_W +: WORD_W];
      OFS_W3:   rd_mux = win_word[3*WORD_W +: WORD_W];
      OFS_IEN:  rd_mux = {{(WORD_W-1){1'b0}}, irq_en};
      OFS_STAT: rd_mux = {{(WORD_W-2){1'b0}}, ovf, !fifo_empty};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/egress_ts_fifo.sv
module egress_ts_fifo
  import egts_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cap_valid,
  input  logic [7:0]  cap_domain,
  input  logic [3:0]  cap_msgtype,
  input  logic [15:0] cap_seqid,
  input  logic [4:0]  cap_sec,
  input  logic [29:0] cap_nsec,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rd_data,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH + 1);

  ts_rec_t          cap_rec, win_rec;
  logic             win_vld, fifo_full, fifo_empty, fifo_drop;
  logic [CW-1:0]    fifo_cnt;
  logic [WIN_W-1:0] win_word;
  logic             pop_cmd, irq_en, ovf;

  assign cap_rec  = '{dom: cap_domain, mtype: cap_msgtype, seq: cap_seqid,
                      sec: cap_sec, ns: cap_nsec};
  assign win_word = pack_window(win_rec, win_vld);

  egts_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .push     (cap_valid),
    .push_rec (cap_rec),
    .pop      (pop_cmd),
    .win_rec  (win_rec),
    .win_vld  (win_vld),
    .count    (fifo_cnt),
    .full     (fifo_full),
    .empty    (fifo_empty),
    .drop     (fifo_drop)
  );

  egts_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .win_word   (win_word),
    .fifo_empty (fifo_empty),
    .drop       (fifo_drop),
    .pop_cmd    (pop_cmd),
    .irq_en     (irq_en),
    .ovf        (ovf),
    .irq        (irq),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/egts_chk.sv
module egts_chk
  import egts_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              cap_valid,
  input logic              wr_en,
  input logic [REG_AW-1:0] addr,
  input logic [WORD_W-1:0] wdata,
  input logic              pop_cmd,
  input logic [WIN_W-1:0]  win_word,
  input logic              fifo_full,
  input logic              fifo_empty,
  input logic [CW-1:0]     fifo_cnt,
  input logic              irq_en,
  input logic              ovf,
  input logic              irq
);
  AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pop_cmd |=> $stable(win_word)); // R6
  AST_EMPTY_POP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (pop_cmd && fifo_empty) |=> (win_word == '0)); // R5
  AST_POP_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
    (pop_cmd && !fifo_empty) |=> win_word[15]); // R4
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq); // R7
  AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (rst)
    fifo_empty |=> !irq); // R7
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && fifo_full && !pop_cmd) |=> (ovf && $stable(fifo_cnt))); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !(wr_en && addr == OFS_STAT && wdata[1])) |=> ovf); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CW'(DEPTH)); // R8
endmodule

bind egress_ts_fifo egts_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cap_valid  (cap_valid),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .pop_cmd    (pop_cmd),
  .win_word   (win_word),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .fifo_cnt   (fifo_cnt),
  .irq_en     (irq_en),
  .ovf        (ovf),
  .irq        (irq)
);

// File: tb/egress_ts_fifo_tb.sv
module egress_ts_fifo_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_valid = 1'b0;
  logic [7:0]  cap_domain = '0;
  logic [3:0]  cap_msgtype = '0;
  logic [15:0] cap_seqid = '0;
  logic [4:0]  cap_sec = '0;
  logic [29:0] cap_nsec = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  egress_ts_fifo u_dut (
    .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_domain(cap_domain),
    .cap_msgtype(cap_msgtype), .cap_seqid(cap_seqid), .cap_sec(cap_sec),
    .cap_nsec(cap_nsec), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic capture(input logic [7:0] dm, input logic [3:0] mt,
                         input logic [15:0] sq, input logic [4:0] sc,
                         input logic [29:0] ns);
    @(negedge clk);
    cap_valid = 1'b1; cap_domain = dm; cap_msgtype = mt;
    cap_seqid = sq; cap_sec = sc; cap_nsec = ns;
    @(negedge clk);
    cap_valid = 1'b0;
  endtask

  task automatic pop();
    reg_write(3'd4, 16'h0001);
  endtask

  task automatic check_window(input string req, input logic [7:0] dm,
                              input logic [3:0] mt, input logic [15:0] sq,
                              input logic [4:0] sc, input logic [29:0] ns);
    logic [15:0] w;
    reg_read(3'd0, w); chk(req, "word0", w, {1'b1, sc[4:2], mt, dm});
    reg_read(3'd1, w); chk(req, "word1", w, sq);
    reg_read(3'd2, w); chk(req, "word2", w, ns[15:0]);
    reg_read(3'd3, w); chk(req, "word3", w, {sc[1:0], ns[29:16]});
  endtask

  task automatic t_reset();
    logic [15:0] w;
    for (int i = 0; i < 4; i++) begin
      reg_read(3'(i), w); chk("R9", "window after reset", w, 16'h0);
    end
    reg_read(3'd6, w); chk("R9", "status after reset", w, 16'h0);
    reg_read(3'd5, w); chk("R9", "enable after reset", w, 16'h0);
    chk("R9", "irq after reset", irq, 1'b0);
  endtask

  task automatic t_packing();
    logic [15:0] w;
    capture(8'hA5, 4'h3, 16'hBEEF, 5'b10110, 30'h2ABC_D123);
    pop();
    check_window("R1 R2 R3", 8'hA5, 4'h3, 16'hBEEF, 5'b10110, 30'h2ABC_D123);
    capture(8'h01, 4'hC, 16'h0F0F, 5'b01001, 30'h1555_AAAA);
    pop();
    check_window("R1 R2 R3", 8'h01, 4'hC, 16'h0F0F, 5'b01001, 30'h1555_AAAA);
    reg_read(3'd6, w); chk("R7", "status empty after pops", w, 16'h0);
  endtask

  task automatic t_order();
    logic [15:0] w;
    for (int i = 0; i < 3; i++)
      capture(8'(i), 4'(i), 16'h1000 + 16'(i), 5'(i), 30'(i * 7));
    pop();
    reg_read(3'd1, w); chk("R4", "first out", w, 16'h1000);
    reg_write(3'd4, 16'h0002);
    reg_read(3'd1, w); chk("R4", "pop with bit0=0 ignored", w, 16'h1000);
    pop();
    reg_read(3'd1, w); chk("R4", "second out", w, 16'h1001);
    pop();
    check_window("R4", 8'd2, 4'd2, 16'h1002, 5'd2, 30'd14);
  endtask

  task automatic t_empty_pop();
    logic [15:0] w;
    pop();
    for (int i = 0; i < 4; i++) begin
      reg_read(3'(i), w); chk("R5", "empty pop window", w, 16'h0);
    end
  endtask

  task automatic t_stable();
    capture(8'h11, 4'h1, 16'h2222, 5'h1F, 30'h3FFF_FFFF);
    pop();
    capture(8'h33, 4'h2, 16'h4444, 5'h00, 30'h0);
    repeat (3) @(negedge clk);
    check_window("R6", 8'h11, 4'h1, 16'h2222, 5'h1F, 30'h3FFF_FFFF);
    pop();
    check_window("R6", 8'h33, 4'h2, 16'h4444, 5'h00, 30'h0);
  endtask

  task automatic t_irq();
    logic [15:0] w;
    capture(8'h07, 4'h0, 16'h0077, 5'h3, 30'h77);
    @(negedge clk);
    chk("R7", "irq with enable off", irq, 1'b0);
    reg_read(3'd6, w); chk("R7", "status nonempty", w, 16'h1);
    reg_write(3'd5, 16'h0001);
    @(negedge clk);
    chk("R7", "irq enabled with data", irq, 1'b1);
    repeat (4) @(negedge clk);
    chk("R7", "irq held without ack", irq, 1'b1);
    pop();
    @(negedge clk);
    chk("R7", "irq after drain", irq, 1'b0);
    reg_write(3'd5, 16'h0000);
  endtask

  task automatic t_overflow();
    logic [15:0] w;
    for (int i = 0; i < 9; i++)
      capture(8'h40, 4'h8, 16'd100 + 16'(i), 5'h0, 30'(i));
    reg_read(3'd6, w); chk("R8", "full with overflow", w, 16'h3);
    for (int i = 0; i < 8; i++) begin
      pop();
      reg_read(3'd1, w); chk("R8", "kept entry order", w, 16'd100 + 16'(i));
    end
    pop();
    reg_read(3'd0, w); chk("R8", "ninth entry dropped", w, 16'h0);
    reg_read(3'd6, w); chk("R8", "overflow sticky", w, 16'h2);
    reg_write(3'd6, 16'h0002);
    reg_read(3'd6, w); chk("R8", "overflow cleared", w, 16'h0);
  endtask

  task automatic t_unused();
    logic [15:0] w;
    reg_read(3'd7, w); chk("R10", "offset 7 reads zero", w, 16'h0);
    reg_read(3'd4, w); chk("R10", "pop offset reads zero", w, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_packing();
    t_order();
    t_empty_pop();
    t_stable();
    t_irq();
    t_overflow();
    t_unused();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule